// File: doc/BRIEF.md
# DRAM Strobe Sequencer with CAS-before-RAS Refresh

This block drives an asynchronous DRAM array that sits behind an 8-bit CPU. It runs from a fast clock at twice the CPU rate, divides that clock by two to give the CPU its clock, and turns the CPU memory-request, read, write and refresh strobes into active-low RAS, CAS and WE. It also switches the DRAM address lines from the row half to the column half of the CPU address. A chip-select from the system address decoder qualifies normal accesses.

The strobe timing comes from a short shift register. The registered memory request enters it on every fast clock edge. The first stage opens RAS, the next stage flips the address multiplexer to the column half, and the stage after that opens CAS. On writes, CAS waits for the CPU write strobe, so the DRAM sees an early write and keeps its data pins quiet. During a CPU refresh cycle the RAS and CAS taps trade places, which gives a CAS-before-RAS refresh that needs no refresh address.

Top module: `dram_strobe_seq`

## Requirements
- R1: `cpuClk` changes level on every rising edge of `clk` once reset is released, and is 0 while reset is held.
- R2: In a selected non-refresh read (memReqN=0, dramSelN=0, rfshN=1, rdN=0), `rasN` goes low after the first `clk` edge that registers the request and `casN` goes low two edges after that. `casN` is never low in a normal cycle unless `rasN` is low.
- R3: `dramAddr` carries `cpuAddr[7:0]` (row) until one edge after RAS falls. From then until the request has drained from the sequencer it carries `cpuAddr[15:8]` (column). It always carries one of the two halves.
- R4: In a selected non-refresh cycle with both rdN and wrN high, `casN` stays high even when its tap is active. It goes low in the same cycle that wrN goes low.
- R5: `weN` is low only when wrN=0, dramSelN=0 and rfshN=1. `weN` is high throughout any refresh cycle, whatever the other inputs are.
- R6: In a refresh cycle (memReqN=0, rfshN=0), `casN` goes low after the first edge that registers the request and `rasN` goes low one edge later. The chip-select has no effect on this.
- R7: With dramSelN=1 and rfshN=1, `rasN` and `casN` stay high, and the request is not registered into the sequencer.
- R8: While `rstN` is low, `rasN`, `casN` and `weN` are high, and the sequencer stages clear to inactive. A request present at reset release therefore starts a fresh RAS-first sequence.
- R9: When memReqN returns high, `rasN` and `casN` return high in that same cycle, while the address select drains through its stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the CPU clock rate |
| rstN | input | 1 | Active-low reset |
| memReqN | input | 1 | CPU memory request, active low |
| rdN | input | 1 | CPU read strobe, active low |
| wrN | input | 1 | CPU write strobe, active low |
| rfshN | input | 1 | CPU refresh cycle indicator, active low |
| dramSelN | input | 1 | DRAM chip-select from address decode, active low |
| cpuAddr | input | 16 | CPU address |
| dramAddr | output | 8 | Multiplexed row/column address to the DRAM |
| rasN | output | 1 | Row address strobe, active low |
| casN | output | 1 | Column address strobe, active low |
| weN | output | 1 | DRAM write enable, active low |
| cpuClk | output | 1 | Divided clock for the CPU |

## Verification
The bench tries the sequencer with four patterns. A selected read shows the RAS, address-switch and CAS order. A selected write whose strobe arrives late tells a held-off CAS apart from one opened by its tap alone. Reads and writes with the chip-select inactive separate gated requests from registered ones. Refresh cycles, one of them with the write strobe and chip-select both active, show that the taps are swapped and that WE stays high. Directed tests reset the block in the middle of an access and check that the sequence restarts RAS-first. They also check that the CPU clock alternates on each edge.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

  // Strobe bundle passed from control to datapath, all active high.
  typedef struct packed {
    logic ras;
    logic cas;
    logic colSel;
    logic we;
  } strobe_t;

endpackage

// File: rtl/dram_seq_tapline.sv
`timescale 1ns/1ps
// Shift register holding the request history; stage 0 is the newest.
module dram_seq_tapline #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqIn,
  output logic [DEPTH-1:0] tapAct
);

  // Stored active low so that a cleared line reads all ones.
  logic [DEPTH-1:0] stageN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageN <= '1;
    end else begin
      stageN <= {stageN[DEPTH-2:0], ~reqIn};
    end
  end

  assign tapAct = ~stageN;

endmodule

// File: rtl/dram_seq_ctrl.sv
`timescale 1ns/1ps
// Cycle decode and tap selection; drives the strobe struct.
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int RAS_TAP      = 0,
  parameter int MUX_TAP      = 1,
  parameter int CAS_TAP      = 2,
  parameter int REFRESH_LEAD = 1,
  parameter int DEPTH        = CAS_TAP + 1
) (
  input  logic             memReqN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             rfshN,
  input  logic             dramSelN,
  input  logic [DEPTH-1:0] tapAct,
  output logic             reqIn,
  output strobe_t          stb
);

  localparam int RFSH_RAS_TAP = RAS_TAP + REFRESH_LEAD;

  logic normalCyc;
  logic refreshCyc;
  logic cpuStrobe;
  logic normalRas;
  logic normalCas;
  logic refreshRas;
  logic refreshCas;

  assign normalCyc  = !memReqN && rfshN && !dramSelN;
  assign refreshCyc = !memReqN && !rfshN;
  assign cpuStrobe  = !rdN || !wrN;

  // Only qualified cycles feed the sequencer.
  assign reqIn = normalCyc || refreshCyc;

  // Normal cycle: RAS tap opens RAS, CAS tap opens CAS once a CPU strobe is present.
  assign normalRas = normalCyc && tapAct[RAS_TAP];
  assign normalCas = normalCyc && tapAct[CAS_TAP] && cpuStrobe;

  // Refresh cycle: the earliest tap opens CAS, a later tap opens RAS.
  assign refreshCas = refreshCyc && tapAct[RAS_TAP];
  assign refreshRas = refreshCyc && tapAct[RFSH_RAS_TAP];

  always_comb begin
    stb        = '0;
    stb.ras    = normalRas || refreshRas;
    stb.cas    = normalCas || refreshCas;
    stb.colSel = tapAct[MUX_TAP];
    stb.we     = !wrN && !dramSelN && rfshN;
  end

endmodule

// File: rtl/dram_seq_datapath.sv
`timescale 1ns/1ps
// Address multiplexer and active-low output stage with reset gating.
module dram_seq_datapath
  import dram_seq_pkg::*;
#(
  parameter int CPU_AW  = 16,
  parameter int DRAM_AW = CPU_AW / 2
) (
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [CPU_AW-1:0]  cpuAddr,
  output logic [DRAM_AW-1:0] dramAddr,
  output logic               rasN,
  output logic               casN,
  output logic               weN
);

  genvar b;
  generate
    for (b = 0; b < DRAM_AW; b++) begin : g_addrMux
      assign dramAddr[b] = stb.colSel ? cpuAddr[b + DRAM_AW] : cpuAddr[b];
    end
  endgenerate

  assign rasN = !(rstN && stb.ras);
  assign casN = !(rstN && stb.cas);
  assign weN  = !(rstN && stb.we);

endmodule

// File: rtl/dram_seq_clkdiv.sv
`timescale 1ns/1ps
// Divide-by-two toggle for the CPU clock.
module dram_seq_clkdiv (
  input  logic clk,
  input  logic rstN,
  output logic cpuClk
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuClk <= 1'b0;
    end else begin
      cpuClk <= ~cpuClk;
    end
  end

endmodule

// File: rtl/dram_strobe_seq.sv
`timescale 1ns/1ps
module dram_strobe_seq
  import dram_seq_pkg::*;
#(
  parameter int CPU_AW       = 16,
  parameter int MUX_LAG      = 1,
  parameter int CAS_LAG      = 1,
  parameter int REFRESH_LEAD = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                memReqN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic                rfshN,
  input  logic                dramSelN,
  input  logic [CPU_AW-1:0]   cpuAddr,
  output logic [CPU_AW/2-1:0] dramAddr,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic                cpuClk
);

  localparam int DRAM_AW = CPU_AW / 2;
  localparam int RAS_TAP = 0;
  localparam int MUX_TAP = RAS_TAP + MUX_LAG;
  localparam int CAS_TAP = MUX_TAP + CAS_LAG;
  localparam int DEPTH   = CAS_TAP + 1;

  logic             reqIn;
  logic [DEPTH-1:0] tapAct;
  strobe_t          stb;

  dram_seq_tapline #(.DEPTH(DEPTH)) u_tapline (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .tapAct (tapAct)
  );

  dram_seq_ctrl #(
    .RAS_TAP      (RAS_TAP),
    .MUX_TAP      (MUX_TAP),
    .CAS_TAP      (CAS_TAP),
    .REFRESH_LEAD (REFRESH_LEAD),
    .DEPTH        (DEPTH)
  ) u_ctrl (
    .memReqN  (memReqN),
    .rdN      (rdN),
    .wrN      (wrN),
    .rfshN    (rfshN),
    .dramSelN (dramSelN),
    .tapAct   (tapAct),
    .reqIn    (reqIn),
    .stb      (stb)
  );

  dram_seq_datapath #(.CPU_AW(CPU_AW), .DRAM_AW(DRAM_AW)) u_datapath (
    .rstN     (rstN),
    .stb      (stb),
    .cpuAddr  (cpuAddr),
    .dramAddr (dramAddr),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN)
  );

  dram_seq_clkdiv u_clkdiv (
    .clk    (clk),
    .rstN   (rstN),
    .cpuClk (cpuClk)
  );

endmodule

// File: rtl/dram_strobe_seq_chk.sv
`timescale 1ns/1ps
module dram_strobe_seq_chk #(
  parameter int CPU_AW = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                memReqN,
  input logic                rfshN,
  input logic                dramSelN,
  input logic [CPU_AW-1:0]   cpuAddr,
  input logic [CPU_AW/2-1:0] dramAddr,
  input logic                rasN,
  input logic                casN,
  input logic                weN,
  input logic                cpuClk
);

  localparam int DAW = CPU_AW / 2;

  // R1
  cpu_clk_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cpuClk != $past(cpuClk));

  // R2
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && rfshN) |-> !rasN);

  // R3
  col_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && rfshN) |-> dramAddr == cpuAddr[2*DAW-1:DAW]);

  // R3
  addr_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dramAddr == cpuAddr[DAW-1:0]) || (dramAddr == cpuAddr[2*DAW-1:DAW]));

  // R5
  refresh_we_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rfshN |-> weN);

  // R6
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqN && !rfshN && $fell(rasN)) |-> !casN);

  // R7
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dramSelN && rfshN) |-> (rasN && casN));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (rasN && casN && weN));

endmodule

bind dram_strobe_seq dram_strobe_seq_chk #(.CPU_AW(CPU_AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memReqN  (memReqN),
  .rfshN    (rfshN),
  .dramSelN (dramSelN),
  .cpuAddr  (cpuAddr),
  .dramAddr (dramAddr),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .cpuClk   (cpuClk)
);

// File: tb/dram_strobe_seq_bench.sv
`timescale 1ns/1ps
module dram_strobe_seq_bench;

  typedef struct packed {
    logic       memN;
    logic       rdN;
    logic       wrN;
    logic       rfN;
    logic       selN;
    logic       ras;
    logic       cas;
    logic       we;
    logic       chkA;
    logic [7:0] addr;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 28;
  localparam logic [15:0] ADDR = 16'hA53C;
  localparam logic [7:0]  ROW  = 8'h3C;
  localparam logic [7:0]  COL  = 8'hA5;

  // Inputs for one cycle, then outputs expected just after the next rising edge.
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd2}, // R2 idle
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b1, 1'b1, ROW, 4'd2}, // R2 RAS first
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b1, 1'b1, COL, 4'd3}, // R3 column
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1, 1'b1, COL, 4'd2}, // R2 CAS
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, COL, 4'd9}, // R9 release
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd3}, // R3 back to row
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd9}, // R9
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b1, 1'b1, ROW, 4'd4}, // R4
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b1, 1'b1, COL, 4'd4}, // R4
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b1, 1'b1, COL, 4'd4}, // R4 held off
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b1, COL, 4'd4}, // R4 write strobe
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, COL, 4'd9}, // R9
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd3}, // R3
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd3}, // R3
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd7}, // R7
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd7}, // R7
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd7}, // R7 nothing registered
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd5}, // R5 unselected write
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd7}, // R7
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1, 1'b0, ROW, 4'd6}, // R6 CAS first
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0, ROW, 4'd6}, // R6 then RAS
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b1, 1'b0, ROW, 4'd6}, // R6
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b0, ROW, 4'd9}, // R9
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd3}, // R3
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 1'b0, ROW, 4'd5}, // R5 WE high in refresh
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1, 1'b0, ROW, 4'd5}, // R5
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b0, ROW, 4'd9}, // R9
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 1'b1, ROW, 4'd3}  // R3
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        memReqN, rdN, wrN, rfshN, dramSelN;
  logic [15:0] cpuAddr;
  logic [7:0]  dramAddr;
  logic        rasN, casN, weN, cpuClk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dram_strobe_seq u_dram_strobe_seq (
    .clk      (clk),
    .rstN     (rstN),
    .memReqN  (memReqN),
    .rdN      (rdN),
    .wrN      (wrN),
    .rfshN    (rfshN),
    .dramSelN (dramSelN),
    .cpuAddr  (cpuAddr),
    .dramAddr (dramAddr),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .cpuClk   (cpuClk)
  );

  task automatic checkStrobes(input string tag, input logic eRas, input logic eCas,
                              input logic eWe);
    checks++;
    if ({rasN, casN, weN} !== {eRas, eCas, eWe}) begin
      failures++;
      $display("FAIL %s: ras/cas/we got %b%b%b expected %b%b%b", tag, rasN, casN, weN,
               eRas, eCas, eWe);
    end
  endtask

  task automatic driveIdle();
    memReqN = 1'b1; rdN = 1'b1; wrN = 1'b1; rfshN = 1'b1; dramSelN = 1'b1;
  endtask

  initial begin
    logic c0;
    cpuAddr = ADDR;
    driveIdle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    checkStrobes("R8 reset", 1'b1, 1'b1, 1'b1);
    checks++;
    if (cpuClk !== 1'b0) begin
      failures++;
      $display("FAIL R1 cpuClk in reset got %b expected 0", cpuClk);
    end
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(posedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      memReqN = VEC[i].memN; rdN = VEC[i].rdN; wrN = VEC[i].wrN;
      rfshN = VEC[i].rfN; dramSelN = VEC[i].selN;
      @(posedge clk);
      #1;
      checks++;
      if ({rasN, casN, weN} !== {VEC[i].ras, VEC[i].cas, VEC[i].we} ||
          (VEC[i].chkA && dramAddr !== VEC[i].addr)) begin
        failures++;
        $display("FAIL R%0d vector %0d: ras/cas/we/addr got %b%b%b/%h expected %b%b%b/%h",
                 VEC[i].rq, i, rasN, casN, weN, dramAddr, VEC[i].ras, VEC[i].cas,
                 VEC[i].we, VEC[i].addr);
      end
    end

    // R1 CPU clock alternates on successive edges
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1; c0 = cpuClk;
      @(posedge clk); #1;
      checks++;
      if (cpuClk === c0) begin
        failures++;
        $display("FAIL R1 cpuClk got %b expected %b", cpuClk, ~c0);
      end
    end

    // R8 reset in the middle of a read, release with the request still present
    @(negedge clk);
    memReqN = 1'b0; rdN = 1'b0; dramSelN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checkStrobes("R2 read before reset", 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkStrobes("R8 reset mid-cycle", 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkStrobes("R8 restart RAS only", 1'b0, 1'b1, 1'b1);
    checks++;
    if (dramAddr !== ROW) begin
      failures++;
      $display("FAIL R8 restart addr got %h expected %h", dramAddr, ROW);
    end
    @(negedge clk);
    driveIdle();
    @(posedge clk);
    #1;
    checkStrobes("R9 release after restart", 1'b1, 1'b1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule